// File: doc/BRIEF.md
# Page-Staged Byte Store with Word Address Counter

This block is the storage side of a small two-wire serial memory. It holds a byte array that comes out of reset with every location set to all ones, a word address counter that sets where reads come from, and a staging buffer that covers one page. A protocol front end drives it with single-cycle strobes. One strobe loads an address. One stages a received byte. One consumes a read byte. Two more end a write command, one by committing it and one by discarding it.

Received bytes never go straight into the array. They collect in the page buffer, and the low address bits step on after each byte. The page number is fixed when the address is loaded, so a long burst wraps back to the start of the same page and overwrites bytes staged earlier. Each buffer lane has its own valid bit. A commit copies only the valid lanes into the array and then empties the buffer. A discard empties the buffer and leaves the array as it was. The front end raises the commit strobe only for a command that ended with a stop and that the write-control logic allowed to proceed. Every other ending is a discard.

The read data output always shows the array byte at the counter address. Each consumed read byte moves the counter on by one over the full address range, so a current read that follows a read of address n returns n+1. Staging and committing bytes never move the counter, so after a write to address n a current read returns n.

Top module: `paged_store`

## Requirements
- R1: After synchronous active-low reset every array location reads 8'hFF and the address counter is 0, so the first read without an address load returns location 0.
- R2: A load strobe sets the counter to the given address. In the following cycle the read data output shows the array byte at that address.
- R3: Each read strobe consumes the byte shown on the read data output and moves the counter on by one. The counter wraps from the top address to 0.
- R4: A load strobe fixes the page (address bits 7..4) and the starting lane (bits 3..0). Each staged byte goes to the current lane, and then only the lane steps on, wrapping from 15 to 0 inside the same page.
- R5: When more than 16 bytes are staged before a commit, a lane written again keeps the newest byte.
- R6: Staged bytes do not reach the array before a commit. Reads of the page during staging return its previous contents.
- R7: A commit writes the valid lanes into the page and leaves the other locations of that page unchanged. It also empties the buffer.
- R8: A discard empties the buffer and leaves the array unchanged, so a later commit with no new bytes writes nothing.
- R9: Staging and committing do not move the counter. After a write loaded at address n, a current read returns location n, including the newly committed byte.
- R10: When discard and commit arrive in the same cycle, the discard wins and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load-address strobe |
| addr_i | input | ADDR_W | Address taken by the load strobe |
| wr_i | input | 1 | Stage-one-byte strobe |
| wr_data_i | input | DATA_W | Byte to stage |
| rd_i | input | 1 | Read-byte strobe (consumes rd_data_o, steps the counter) |
| commit_i | input | 1 | Commit the staged page into the array |
| discard_i | input | 1 | Drop the staged page |
| rd_data_o | output | DATA_W | Array byte at the counter address |

## Verification
The bench builds the block with its default parameters: an 8-bit address (256 bytes), 8-bit data and a 16-byte page. With these values a short run reaches the counter wrap from the top address to 0, a page wrap at the end of a page and a burst of more than one page. A reference model of the array, counter and staging lanes, written from the requirements, predicts every read byte. A monitor compares each prediction with the output in the cycle of the read strobe. The scenarios cover a partial page, a burst that wraps the page, a burst that overflows it, a discard, a discard that coincides with a commit, and current reads after both reads and writes.

// File: rtl/paged_store_pkg.sv
// Shared types for the page-staged byte store.
// Assumes: one staging operation is chosen per cycle.
package paged_store_pkg;

    // Action taken on the page buffer in one cycle, highest priority first
    typedef enum logic [1:0] {
        STG_DROP   = 2'd0,
        STG_COMMIT = 2'd1,
        STG_WRITE  = 2'd2,
        STG_IDLE   = 2'd3
    } stage_op_e;

    // Pick the buffer action from the strobes; discard outranks commit
    function automatic stage_op_e pick_stage_op(input logic drop,
                                                input logic commit,
                                                input logic wr);
        if (drop)        return STG_DROP;
        else if (commit) return STG_COMMIT;
        else if (wr)     return STG_WRITE;
        else             return STG_IDLE;
    endfunction

endpackage

// File: rtl/ps_addr_counter.sv
// Word address counter. A load sets it and a read step advances it by one,
// wrapping over the full address range. Nothing else moves it.
// Assumes: load and step are single-cycle strobes; load has priority.
module ps_addr_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cnt_o
);

    logic [ADDR_W-1:0] cnt_q;

    // Counter register: reset to 0, load, or step with natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= addr_i;
        end else if (step_i) begin
            cnt_q <= cnt_q + ADDR_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ps_page_stager.sv
// One-page staging buffer with a valid bit per lane. A load fixes the page
// and the starting lane. Each staged byte fills the current lane, and then
// the lane index steps on, wrapping inside the page. Commit or discard empties
// the buffer. A commit that survives a coincident discard is flagged to the
// array for one cycle.
// Assumes: a load in the same cycle as a write wins for the lane index.
module ps_page_stager
    import paged_store_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       wr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       commit_i,
    input  logic                       discard_i,
    output logic                       commit_o,
    output logic [ADDR_W-PAGE_W-1:0]   base_o,
    output logic [(1<<PAGE_W)-1:0]     valid_o,
    output logic [(1<<PAGE_W)*DATA_W-1:0] lanes_o
);

    localparam int LANES = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;

    logic [DATA_W-1:0] stage_q [LANES];
    logic [LANES-1:0]  vld_q;
    logic [PAGE_W-1:0] lane_q;
    logic [HI_W-1:0]   base_q;
    stage_op_e         op;

    // Decode this cycle's buffer action
    always_comb begin
        op = pick_stage_op(discard_i, commit_i, wr_i);
    end

    // Buffer, valid mask, lane index and page base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) begin
                stage_q[i] <= '0;
            end
            vld_q  <= '0;
            lane_q <= '0;
            base_q <= '0;
        end else begin
            case (op)
                STG_DROP, STG_COMMIT: vld_q <= '0;
                STG_WRITE: begin
                    stage_q[lane_q] <= wr_data_i;
                    vld_q[lane_q]   <= 1'b1;
                    lane_q          <= lane_q + PAGE_W'(1);
                end
                default: ;
            endcase
            if (load_i) begin
                lane_q <= addr_i[PAGE_W-1:0];
                base_q <= addr_i[ADDR_W-1:PAGE_W];
            end
        end
    end

    // Flatten the lanes for the array
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_o[g*DATA_W +: DATA_W] = stage_q[g];
    end

    assign commit_o = (op == STG_COMMIT);
    assign base_o   = base_q;
    assign valid_o  = vld_q;

endmodule

// File: rtl/ps_store_array.sv
// Register-file byte array, reset to all ones. On a commit, each valid lane
// of the staged page is written to its address in the page. Reads are
// combinational at the given address.
// Assumes: at most one page is committed per cycle.
module ps_store_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]      base_i,
    input  logic [(1<<PAGE_W)-1:0]        mask_i,
    input  logic [(1<<PAGE_W)*DATA_W-1:0] lanes_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = 1 << PAGE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Array storage: fill with ones on reset, write valid lanes on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (commit_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask_i[l]) begin
                    mem_q[{base_i, PAGE_W'(l)}] <= lanes_i[l*DATA_W +: DATA_W];
                end
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/paged_store.sv
// Top of the page-staged byte store: address counter, page stager and array.
// The read data output always shows the byte at the counter. Writes pass
// through the stager and reach the array only on commit.
// Assumes: the front end raises commit_i only for a granted, stop-ended write.
module paged_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    input  logic              commit_i,
    input  logic              discard_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int LANES = 1 << PAGE_W;
    localparam int HI_W  = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0]       cnt_q;
    logic                    commit_en;
    logic [HI_W-1:0]         page_base;
    logic [LANES-1:0]        lane_vld;
    logic [LANES*DATA_W-1:0] lane_data;

    ps_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .addr_i (addr_i),
        .step_i (rd_i),
        .cnt_o  (cnt_q)
    );

    ps_page_stager #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .addr_i    (addr_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .commit_i  (commit_i),
        .discard_i (discard_i),
        .commit_o  (commit_en),
        .base_o    (page_base),
        .valid_o   (lane_vld),
        .lanes_o   (lane_data)
    );

    ps_store_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit_en),
        .base_i    (page_base),
        .mask_i    (lane_vld),
        .lanes_i   (lane_data),
        .rd_addr_i (cnt_q),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/paged_store_chk.sv
// Assertion checker for paged_store, attached with bind below.
module paged_store_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load_i,
    input logic [ADDR_W-1:0]       addr_i,
    input logic                    rd_i,
    input logic                    commit_i,
    input logic                    discard_i,
    input logic [ADDR_W-1:0]       cnt_q,
    input logic [(1<<PAGE_W)-1:0]  lane_vld,
    input logic [DATA_W-1:0]       rd_data_o
);

    // R2: a load sets the counter
    p_load_sets_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(addr_i));

    // R3: a read step advances the counter by one, wrapping
    p_step_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> cnt_q == ADDR_W'($past(cnt_q) + ADDR_W'(1)));

    // R9: without load or read the counter holds, whatever the write strobes do
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !load_i) |=> $stable(cnt_q));

    // R6: without a commit and with the counter still, the read data holds
    p_array_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !rd_i && !load_i) |=> $stable(rd_data_o));

    // R7, R8: commit or discard leaves the buffer empty
    p_buf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i || discard_i) |=> lane_vld == '0);

    // R10: a discard that meets a commit writes nothing
    p_drop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_i && !rd_i && !load_i) |=> $stable(rd_data_o));

endmodule

bind paged_store paged_store_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .commit_i  (commit_i),
    .discard_i (discard_i),
    .cnt_q     (cnt_q),
    .lane_vld  (lane_vld),
    .rd_data_o (rd_data_o)
);

// File: tb/paged_store_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks update a requirement-level model and push
// expected read bytes; a monitor pops and compares on each read strobe.
module paged_store_test;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 4;
    localparam int LANES  = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              wr_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic              rd_i = 1'b0;
    logic              commit_i = 1'b0;
    logic              discard_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [DATA_W-1:0] m_stage [LANES];
    logic [LANES-1:0]  m_vld = '0;
    logic [ADDR_W-1:0] m_cnt = '0;
    logic [PAGE_W-1:0] m_lane = '0;
    logic [ADDR_W-PAGE_W-1:0] m_base = '0;

    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #10 clk = ~clk;

    paged_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i),
        .commit_i(commit_i), .discard_i(discard_i), .rd_data_o(rd_data_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        load_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
        commit_i = 1'b0; discard_i = 1'b0;
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a);
        load_i = 1'b1; addr_i = a;
        m_cnt = a; m_lane = a[PAGE_W-1:0]; m_base = a[ADDR_W-1:PAGE_W];
        tick();
    endtask

    task automatic do_write(input logic [DATA_W-1:0] d);
        wr_i = 1'b1; wr_data_i = d;
        m_stage[m_lane] = d; m_vld[m_lane] = 1'b1; m_lane = m_lane + 1'b1;
        tick();
    endtask

    task automatic do_commit();
        commit_i = 1'b1;
        for (int l = 0; l < LANES; l++)
            if (m_vld[l]) m_mem[{m_base, PAGE_W'(l)}] = m_stage[l];
        m_vld = '0;
        tick();
    endtask

    task automatic do_discard();
        discard_i = 1'b1; m_vld = '0;
        tick();
    endtask

    task automatic do_both();
        discard_i = 1'b1; commit_i = 1'b1; m_vld = '0;
        tick();
    endtask

    task automatic do_read(input string tag);
        exp_q.push_back(m_mem[m_cnt]);
        tag_q.push_back(tag);
        rd_i = 1'b1;
        m_cnt = m_cnt + 1'b1;
        tick();
    endtask

    // Monitor: compare each consumed byte against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_i) begin
            logic [DATA_W-1:0] e;
            string t;
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: actual %h expected none", rd_data_o);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data_o !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data_o, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, direct output check then reads from address 0
        tests++;
        if (rd_data_o !== 8'hFF) begin
            fails++;
            $display("FAIL R1 reset output: actual %h expected ff", rd_data_o);
        end
        do_read("R1 addr0");
        do_read("R1 addr1");

        // R6, R7: partial page, reads before commit see old data
        do_load(8'h20);
        do_write(8'hA0); do_write(8'hA1); do_write(8'hA2);
        do_read("R6 before commit");
        do_commit();
        do_load(8'h20);
        do_read("R2 R7 lane0"); do_read("R7 lane1"); do_read("R7 lane2");
        do_read("R7 untouched lane3");

        // R4: burst wraps inside the page, no carry to next page
        do_load(8'h3C);
        for (int i = 0; i < 6; i++) do_write(8'hB0 + 8'(i));
        do_commit();
        do_load(8'h3F);
        do_read("R4 lane f"); do_read("R4 next page untouched");
        do_load(8'h30);
        do_read("R4 wrapped lane0"); do_read("R4 wrapped lane1");
        do_read("R4 lane2 untouched");

        // R5: 18 bytes overflow the page, newest byte wins
        do_load(8'h50);
        for (int i = 0; i < 18; i++) do_write(8'hC0 + 8'(i));
        do_commit();
        do_load(8'h50);
        for (int i = 0; i < LANES; i++) do_read("R5 overflow page");

        // R8: discard drops the staged bytes; later commit writes nothing
        do_load(8'h70);
        do_write(8'hD0); do_write(8'hD1);
        do_discard();
        do_commit();
        do_load(8'h70);
        do_read("R8 lane0"); do_read("R8 lane1");

        // R10: discard and commit together write nothing
        do_load(8'h80);
        do_write(8'hE0);
        do_both();
        do_commit();
        do_load(8'h80);
        do_read("R10 lane0");

        // R9: write then current read at the loaded address
        do_load(8'h90);
        do_write(8'h5A);
        do_commit();
        do_read("R9 current read after write");
        do_read("R3 current read after read");

        // R3: counter wraps from top to 0
        do_load(8'h00); do_write(8'h11); do_commit();
        do_load(8'hFF); do_write(8'h99); do_commit();
        do_load(8'hFE);
        do_read("R3 addr fe"); do_read("R3 addr ff"); do_read("R3 wrap to 0");

        repeat (2) @(posedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard drain: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule